// File: doc/BRIEF.md
# Sector Hamming ECC Engine

This block computes a single-error-correcting Hamming code over one data sector of a NAND page. The sector is 512 bytes by default. The bytes arrive on an 8-bit bus with a valid qualifier, and gaps between bytes are allowed. A start pulse clears the running parity. Each accepted byte is then folded into two 12-bit parity halves, indexed by its byte offset and bit position. When the last byte of the sector has been taken, a done flag rises. From then on the packed and inverted 24-bit code on the output stays frozen until the next start.

The same engine serves both directions. On a write, the 24-bit code is stored in the spare area, least significant byte first: byte 0 holds bits 7:0, byte 1 holds bits 15:8 and byte 2 holds bits 23:16. On a read, the sector is streamed through the engine again and the stored code is presented on the stored-code input. The engine compares the two codes and reports one of four outcomes: the sector is clean, a single data bit is correctable at a given byte and bit, only the stored code itself is damaged, or the sector is uncorrectable. The rewrite of the data buffer is left to the consumer of the error location.

Top module: `sector_ecc_engine`

## Requirements
- R1: A low reset or an accepted start clears all parity and the byte count, so the code output reads 0xFFFFFF with done low on the next cycle. A byte presented in the same cycle as start is not taken.
- R2: A data bit at byte offset o and bit position b has index i = 8*o + b (12 bits). For every k in 0..11, parity bit k+12 accumulates the data bits whose index bit k is 1, and parity bit k accumulates the data bits whose index bit k is 0. The code output is the bitwise inverse of that 24-bit parity word.
- R3: A sector made entirely of 0xFF bytes yields code 0xFFFFFF, which is the value of an erased spare area, so it classifies as clean against a stored 0xFFFFFF.
- R4: Only cycles with the valid input high advance the byte count. Idle cycles between bytes leave the result unchanged.
- R5: The done output goes high in the cycle after the clock edge that takes the last byte of the sector. While done is high, valid bytes are ignored and the code holds until the next start.
- R6: The status output is 0 (clean) when the code output equals the stored code.
- R7: When the upper 12 bits of d = code XOR stored, XORed with its lower 12 bits, give 0xFFF and the index d[23:15] lies inside the sector, the status is 1 (correctable). The error byte output is d[23:15] and the error bit output is d[14:12].
- R8: A difference of the correctable form whose byte index d[23:15] is not below the sector size gives status 3 (uncorrectable).
- R9: A difference with exactly one bit set gives status 2 (code-only error).
- R10: Any other nonzero difference gives status 3. For every status other than 1, the error byte and error bit outputs are 0.
- R11: Classification is combinational from the current code and the stored-code input, so a new stored code changes the result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the parity and begins a new sector |
| byte_valid | input | 1 | Qualifies byte_data |
| byte_data | input | 8 | Sector data byte |
| stored_code | input | 24 | Code read back from the spare area |
| code_out | output | 24 | Packed, inverted code of the bytes taken so far |
| done | output | 1 | The whole sector has been taken |
| status | output | 2 | 0 clean, 1 correctable, 2 code-only, 3 uncorrectable |
| err_byte | output | 9 | Byte offset of a correctable error |
| err_bit | output | 3 | Bit position of a correctable error |

## Verification
With the default 512-byte sector, no byte index taken from a difference can fall outside the sector. The out-of-range rejection is therefore unreachable on the default instance. The bench runs a second instance sized for 256-byte sectors on the same inputs and presents a stored code whose correctable-form difference points at byte 300.

A real single-bit data fault is produced by streaming a sector and keeping its code as the stored value. The same sector is then streamed again with one bit flipped. Flipping two bits produces a genuinely uncorrectable pattern.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and helpers for the sector ECC engine.
// Assumes a code made of two 12-bit halves: bit index in the low 3 bits
// and byte offset in the upper 9 bits of each 12-bit index.
package ecc_pkg;
    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = 3;
    localparam int BYTE_IDX_W = 9;
    localparam int HALF_W     = BIT_IDX_W + BYTE_IDX_W;
    localparam int CODE_W     = 2 * HALF_W;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXABLE   = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_UNRECOV   = 2'd3
    } ecc_status_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } parity_t;

    // Mask of the bit positions inside a byte whose position bit k is 1.
    function automatic logic [BYTE_W-1:0] bitpos_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int j = 0; j < BYTE_W; j++) m[j] = ((j >> k) & 1) == 1;
        return m;
    endfunction
endpackage

// File: rtl/ecc_byte_parity.sv
`timescale 1ns/1ps
// Combinational contribution of one byte to both 12-bit parity halves.
// Assumes byte_off is the byte's position inside the sector.
module ecc_byte_parity
    import ecc_pkg::*;
(
    input  logic [BYTE_W-1:0]     byte_data,
    input  logic [BYTE_IDX_W-1:0] byte_off,
    output parity_t               contrib
);
    logic [HALF_W-1:0] hi_bits;
    logic [HALF_W-1:0] lo_bits;
    logic              byte_par;

    // Parity of the whole byte feeds every offset-selected bit.
    assign byte_par = ^byte_data;

    // Index bits that come from the bit position inside the byte.
    for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_bitpos
        localparam logic [BYTE_W-1:0] SEL = bitpos_mask(k);
        assign hi_bits[k] = ^(byte_data & SEL);
        assign lo_bits[k] = ^(byte_data & ~SEL);
    end

    // Index bits that come from the byte offset.
    for (genvar k = BIT_IDX_W; k < HALF_W; k++) begin : g_offset
        assign hi_bits[k] = byte_par &  byte_off[k-BIT_IDX_W];
        assign lo_bits[k] = byte_par & ~byte_off[k-BIT_IDX_W];
    end

    assign contrib = '{hi: hi_bits, lo: lo_bits};
endmodule

// File: rtl/ecc_accum.sv
`timescale 1ns/1ps
// Sector accumulator: counts accepted bytes, folds each byte's parity in,
// and raises done after the last byte of the sector. Start beats data.
// Assumes SECTOR_BYTES <= 512 so every offset fits the 9-bit index.
module ecc_accum
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output parity_t           parity,
    output logic              done
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);

    logic [CNT_W-1:0]      count;
    logic [BYTE_IDX_W-1:0] offset;
    logic                  take;
    parity_t               contrib;
    parity_t               parity_q;

    // A byte is taken only when valid, sector open, and no restart.
    assign take   = byte_valid && !done && !start;
    assign offset = BYTE_IDX_W'(count);

    ecc_byte_parity u_bytepar (
        .byte_data (byte_data),
        .byte_off  (offset),
        .contrib   (contrib)
    );

    // Parity, count and done registers with restart on reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            parity_q <= '0;
            count    <= '0;
            done     <= 1'b0;
        end else if (take) begin
            parity_q <= parity_t'(parity_q ^ contrib);
            count    <= count + 1'b1;
            if (count == LAST) done <= 1'b1;
        end
    end

    assign parity = parity_q;
endmodule

// File: rtl/ecc_classify.sv
`timescale 1ns/1ps
// Compares the computed and stored codes and sorts the difference into
// clean, correctable (with location), code-only and uncorrectable.
// Purely combinational; assumes both codes use the same packing.
module ecc_classify
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0]     code,
    input  logic [CODE_W-1:0]     stored,
    output ecc_status_e           status,
    output logic [BYTE_IDX_W-1:0] err_byte,
    output logic [BIT_IDX_W-1:0]  err_bit
);
    localparam logic [BYTE_IDX_W:0] LIMIT = (BYTE_IDX_W+1)'(SECTOR_BYTES);

    logic [CODE_W-1:0]     diff;
    logic                  complement;
    logic                  in_range;
    logic [BYTE_IDX_W-1:0] idx_byte;
    logic [BIT_IDX_W-1:0]  idx_bit;

    // Difference and its derived tests.
    assign diff       = code ^ stored;
    assign complement = (diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == '1;
    assign idx_byte   = diff[CODE_W-1:HALF_W+BIT_IDX_W];
    assign idx_bit    = diff[HALF_W+BIT_IDX_W-1:HALF_W];
    assign in_range   = {1'b0, idx_byte} < LIMIT;

    // Ordered decision: zero, correctable form, single bit, otherwise.
    always_comb begin
        status   = ST_UNRECOV;
        err_byte = '0;
        err_bit  = '0;
        if (diff == '0) begin
            status = ST_CLEAN;
        end else if (complement) begin
            if (in_range) begin
                status   = ST_FIXABLE;
                err_byte = idx_byte;
                err_bit  = idx_bit;
            end
        end else if ($onehot(diff)) begin
            status = ST_CODE_ONLY;
        end
    end
endmodule

// File: rtl/sector_ecc_engine.sv
`timescale 1ns/1ps
// Top of the sector ECC engine: accumulates parity, packs the two halves
// into a 24-bit code (upper half in 23:12), inverts it so an erased
// sector matches erased spare bytes, and classifies against a stored code.
module sector_ecc_engine
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  byte_valid,
    input  logic [BYTE_W-1:0]     byte_data,
    input  logic [CODE_W-1:0]     stored_code,
    output logic [CODE_W-1:0]     code_out,
    output logic                  done,
    output logic [1:0]            status,
    output logic [BYTE_IDX_W-1:0] err_byte,
    output logic [BIT_IDX_W-1:0]  err_bit
);
    parity_t     parity;
    ecc_status_e status_e;

    ecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .parity     (parity),
        .done       (done)
    );

    // Packing and inversion of the running parity.
    assign code_out = ~{parity.hi, parity.lo};

    ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_classify (
        .code     (code_out),
        .stored   (stored_code),
        .status   (status_e),
        .err_byte (err_byte),
        .err_bit  (err_bit)
    );

    assign status = status_e;
endmodule

// File: rtl/sector_ecc_checker.sv
`timescale 1ns/1ps
// Property checker for sector_ecc_engine, attached by bind below.
module sector_ecc_checker
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  byte_valid,
    input logic [CODE_W-1:0]     stored_code,
    input logic [CODE_W-1:0]     code_out,
    input logic                  done,
    input logic [1:0]            status,
    input logic [BYTE_IDX_W-1:0] err_byte,
    input logic [BIT_IDX_W-1:0]  err_bit
);
    localparam logic [BYTE_IDX_W:0] LIMIT = (BYTE_IDX_W+1)'(SECTOR_BYTES);
    logic [CODE_W-1:0] diff;
    assign diff = code_out ^ stored_code;

    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (code_out == '1 && !done));

    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r5_ignore_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byte_valid && !start) |=> $stable(code_out));

    a_r6_clean_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out == stored_code) |-> (status == ST_CLEAN));

    a_r7_fixable_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_FIXABLE) |-> ((diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == '1));

    a_r8_location_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_FIXABLE) |-> ({1'b0, err_byte} < LIMIT));

    a_r9_code_only_single: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_CODE_ONLY) |-> ($countones(diff) == 1));

    a_r10_location_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status != ST_FIXABLE) |-> (err_byte == '0 && err_bit == '0));
endmodule

bind sector_ecc_engine sector_ecc_checker #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .byte_valid  (byte_valid),
    .stored_code (stored_code),
    .code_out    (code_out),
    .done        (done),
    .status      (status),
    .err_byte    (err_byte),
    .err_bit     (err_bit)
);

// File: tb/tb_sector_ecc_engine.sv
`timescale 1ns/1ps
module tb_sector_ecc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [23:0] stored_code = 24'hFFFFFF;

    logic [23:0] code_b, code_s;
    logic        done_b, done_s;
    logic [1:0]  status_b, status_s;
    logic [8:0]  ebyte_b, ebyte_s;
    logic [2:0]  ebit_b, ebit_s;

    sector_ecc_engine #(.SECTOR_BYTES(512)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
        .byte_data(byte_data), .stored_code(stored_code), .code_out(code_b),
        .done(done_b), .status(status_b), .err_byte(ebyte_b), .err_bit(ebit_b));

    sector_ecc_engine #(.SECTOR_BYTES(256)) dut_small (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
        .byte_data(byte_data), .stored_code(stored_code), .code_out(code_s),
        .done(done_s), .status(status_s), .err_byte(ebyte_s), .err_bit(ebit_s));

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    logic [7:0]  sec [512];
    logic [23:0] good;

    // Behavioural reference: one entry per instance (0 = 512, 1 = 256 bytes).
    int          m_len [2] = '{512, 256};
    int          m_cnt [2];
    logic [23:0] m_raw [2];
    bit          m_done[2];

    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (!rst_n || start) begin
                m_cnt[u] = 0; m_raw[u] = 24'h0; m_done[u] = 1'b0;
            end else if (byte_valid && !m_done[u]) begin
                for (int j = 0; j < 8; j++) begin
                    if (byte_data[j]) begin
                        int idx;
                        idx = m_cnt[u] * 8 + j;
                        for (int k = 0; k < 12; k++) begin
                            if (((idx >> k) & 1) == 1) m_raw[u][12+k] = ~m_raw[u][12+k];
                            else                       m_raw[u][k]    = ~m_raw[u][k];
                        end
                    end
                end
                m_cnt[u] = m_cnt[u] + 1;
                if (m_cnt[u] == m_len[u]) m_done[u] = 1'b1;
            end
        end
    end

    // Expected {status, byte, bit, range-reject flag} from the requirement text.
    function automatic logic [14:0] expect_result(input logic [23:0] code,
                                                  input logic [23:0] st, input int len);
        logic [23:0] d;
        int b;
        d = code ^ st;
        if (d == 24'h0) return {2'd0, 9'd0, 3'd0, 1'b0};
        if (((d >> 12) ^ (d & 24'hFFF)) == 24'hFFF) begin
            b = int'(d >> 15);
            if (b < len) return {2'd1, d[23:15], d[14:12], 1'b0};
            return {2'd3, 9'd0, 3'd0, 1'b1};
        end
        if ($countones(d) == 1) return {2'd2, 9'd0, 3'd0, 1'b0};
        return {2'd3, 9'd0, 3'd0, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmp_unit(input int u, input logic [23:0] code, input logic dn,
                            input logic [1:0] st, input logic [8:0] eb, input logic [2:0] ebt);
        logic [14:0] e;
        string tag;
        e = expect_result(~m_raw[u], stored_code, m_len[u]);
        chk(dn == m_done[u], $sformatf("R5 done unit%0d", u), dn, m_done[u]);
        chk(code == ~m_raw[u], $sformatf("R2 code unit%0d", u), code, ~m_raw[u]);
        case (e[14:13])
            2'd0: tag = "R6";
            2'd1: tag = "R7";
            2'd2: tag = "R9";
            default: tag = e[0] ? "R8" : "R10";
        endcase
        chk({st, eb, ebt} == e[14:1], $sformatf("%s result unit%0d", tag, u),
            {st, eb, ebt}, e[14:1]);
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            cmp_unit(0, code_b, done_b, status_b, ebyte_b, ebit_b);
            cmp_unit(1, code_s, done_s, status_s, ebyte_s, ebit_s);
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1; byte_valid = 1'b0;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic send(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(posedge clk); #1 byte_valid = 1'b0; byte_data = 8'h5A;
            end
            @(posedge clk); #1 byte_valid = 1'b1; byte_data = sec[i];
        end
        @(posedge clk); #1 byte_valid = 1'b0;
    endtask

    task automatic set_stored(input logic [23:0] v);
        @(negedge clk); #1 stored_code = v; #0.5;
    endtask

    task automatic check_fix(input int idx);
        logic [11:0] i12;
        i12 = 12'(idx);
        set_stored(good ^ {i12, ~i12});
        chk(status_b == 2'd1 && ebyte_b == 9'(idx >> 3) && ebit_b == 3'(idx & 7),
            "R7 correctable location", {status_b, ebyte_b, ebit_b},
            {2'd1, 9'(idx >> 3), 3'(idx & 7)});
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk); #0.5;
        chk(code_b == 24'hFFFFFF && !done_b, "R1 reset state", {done_b, code_b}, 24'hFFFFFF);

        // R3: erased sector.
        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        pulse_start();
        send(512, 1'b0);
        set_stored(24'hFFFFFF);
        chk(done_b, "R5 done after full sector", done_b, 1);
        chk(code_b == 24'hFFFFFF, "R3 erased code", code_b, 24'hFFFFFF);
        chk(status_b == 2'd0, "R3 erased clean", status_b, 0);

        // R4: random sector with idle gaps.
        for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
        pulse_start();
        send(512, 1'b1);
        @(negedge clk); #0.5;
        chk(code_b == ~m_raw[0], "R4 gapped sector code", code_b, ~m_raw[0]);
        good = code_b;
        set_stored(good);
        chk(status_b == 2'd0, "R6 matching code clean", status_b, 0);
        set_stored(good ^ 24'h1);   // R11: result follows stored code at once
        chk(status_b == 2'd2, "R11 combinational update", status_b, 2);
        check_fix(0);
        check_fix(4095);
        check_fix(77 * 8 + 5);
        check_fix(1234);
        set_stored(good ^ 24'h000800);
        chk(status_b == 2'd2 && ebyte_b == 0 && ebit_b == 0, "R9 code-only bit 11",
            {status_b, ebyte_b, ebit_b}, {2'd2, 12'd0});
        set_stored(good ^ 24'h800000);
        chk(status_b == 2'd2, "R9 code-only bit 23", status_b, 2);
        set_stored(good ^ 24'h000003);
        chk(status_b == 2'd3 && ebyte_b == 0, "R10 two-bit difference", status_b, 3);
        set_stored(good ^ 24'h0F00F0);
        chk(status_b == 2'd3, "R10 even pattern", status_b, 3);

        // R5: bytes after done are ignored.
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1 byte_valid = 1'b1; byte_data = 8'(i * 37 + 1);
        end
        @(posedge clk); #1 byte_valid = 1'b0;
        @(negedge clk); #0.5;
        chk(code_b == good && done_b, "R5 extra bytes ignored", code_b, good);

        // R7: real single-bit data fault.
        sec[77][5] = ~sec[77][5];
        pulse_start();
        send(512, 1'b0);
        set_stored(good);
        chk(status_b == 2'd1 && ebyte_b == 9'd77 && ebit_b == 3'd5, "R7 flipped data bit",
            {status_b, ebyte_b, ebit_b}, {2'd1, 9'd77, 3'd5});
        // R10: two data faults.
        sec[300][0] = ~sec[300][0];
        pulse_start();
        send(512, 1'b0);
        set_stored(good);
        chk(status_b == 2'd3, "R10 double data fault", status_b, 3);

        // R1: start wins over a byte in the same cycle; then known patterns.
        @(posedge clk); #1 start = 1'b1; byte_valid = 1'b1; byte_data = 8'hA5;
        @(posedge clk); #1 start = 1'b0; byte_valid = 1'b0;
        @(negedge clk); #0.5;
        chk(code_b == 24'hFFFFFF, "R1 start ignores same-cycle byte", code_b, 24'hFFFFFF);
        @(posedge clk); #1 byte_valid = 1'b1; byte_data = 8'h01;
        @(posedge clk); #1 byte_valid = 1'b0;
        @(negedge clk); #0.5;
        chk(code_b == 24'hFFF000, "R2 bit index 0", code_b, 24'hFFF000);
        pulse_start();
        @(posedge clk); #1 byte_valid = 1'b1; byte_data = 8'h00;
        @(posedge clk); #1 byte_data = 8'h80;
        @(posedge clk); #1 byte_valid = 1'b0;
        @(negedge clk); #0.5;
        chk(code_b == 24'hFF000F, "R2 bit index 15", code_b, 24'hFF000F);

        // R8: small instance rejects an index beyond its sector.
        for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
        pulse_start();
        send(512, 1'b0);
        @(negedge clk); #0.5;
        chk(done_s && done_b, "R5 both sizes done", {done_s, done_b}, 2'b11);
        good = code_s;
        set_stored(good ^ {12'(300 * 8 + 2), ~12'(300 * 8 + 2)});
        chk(status_s == 2'd3 && ebyte_s == 0, "R8 byte beyond sector", status_s, 3);
        set_stored(good ^ {12'(100 * 8 + 1), ~12'(100 * 8 + 1)});
        chk(status_s == 2'd1 && ebyte_s == 9'd100 && ebit_s == 3'd1, "R7 small sector fix",
            {status_s, ebyte_s, ebit_s}, {2'd1, 9'd100, 3'd1});

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule